// File: doc/BRIEF.md
# Nibble-Written CHR Bank and Mirroring Register File

This block keeps the bank numbers that map the eight 1 KiB slices of pattern space (PPU $0000-$1FFF) onto a large CHR ROM. It also keeps the nametable arrangement register. The CPU-side decoder supplies already-decoded register writes. A bank write carries a group code, a 2-bit index and a data byte. Each bank number is built up from two separate writes: one supplies the four low bits and the other supplies the upper bits.

On the picture side the block is purely combinational. The PPU address picks one of the eight banks. The CHR ROM address is formed from the selected bank number followed by the ten in-slice address bits. The block also drives the A10 line of the nametable RAM from the current arrangement mode.

Two parameters select between build variants. The full build has 9-bit bank numbers and four arrangement modes. The reduced build has 8-bit bank numbers and only the vertical and horizontal modes. A separate option, intended for one board wiring of the reduced build, shifts the output bank number right by one place. That drops its lowest bit.

Top module: `chr_bank_file`

## Requirements
- R1: The slot written is `wr_grp*2 + wr_idx[1]` (group codes 0..3 cover slots 0-1, 2-3, 4-5, 6-7). The slot read is `ppu_addr[12:10]`, so slot k serves PPU $k*400 to $k*400+3FF.
- R2: A bank write with `wr_idx[0]=0` loads `wr_data[3:0]` into bits 3:0 of the addressed bank. Bits 8:4 of that bank keep their value.
- R3: In the full build, a bank write with `wr_idx[0]=1` loads `wr_data[4:0]` into bits 8:4 of the addressed bank. Bits 3:0 keep their value.
- R4: `chr_addr` equals `{bank, ppu_addr[9:0]}` for the slot that `ppu_addr` selects. It follows `ppu_addr` with no clock delay.
- R5: In the reduced build, a high write loads only `wr_data[3:0]` into bits 7:4. `wr_data[4]` is ignored, and bank bit 8 always reads 0.
- R6: With the drop-LSB option, the bank field of `chr_addr` is the stored bank number shifted right by one, with a 0 at the top.
- R7: In the full build, a mirroring write stores `wr_data[1:0]`. `ciram_a10` is then as follows: mode 0 (vertical) gives `ppu_addr[10]`; mode 1 (horizontal) gives `ppu_addr[11]`; mode 2 gives constant 0; mode 3 gives constant 1.
- R8: In the reduced build, mirroring `wr_data[1]` is ignored. A write of $FF selects horizontal and a write of 2 selects vertical.
- R9: After reset, every bank is 0 and the mirroring mode is vertical.
- R10: Writes take effect at the clock edge on which the strobe is sampled. Without a strobe, banks and mode keep their values.
- R11: Mirroring writes leave every bank unchanged. Bank writes leave the mirroring mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_chr | input | 1 | Bank write strobe |
| wr_grp | input | 2 | Bank write group code (0..3) |
| wr_idx | input | 2 | Index within group: bit 1 picks the bank, bit 0 picks the half |
| wr_mir | input | 1 | Mirroring write strobe |
| wr_data | input | 8 | Write data |
| ppu_addr | input | 14 | PPU address |
| chr_addr | output | 19 | CHR ROM address: bank number and in-slice offset |
| ciram_a10 | output | 1 | Nametable RAM A10 line |

## Verification
The bench writes the low and high halves of a bank in both orders. It then checks that each half survives a later write to the other half. A design that assembled the bank from one write would wipe the opposite half. The bench also writes all eight slots with distinct values and reads each back through its own PPU window. A swapped group or index decode would show one slot's bank in another slot's window.

The reduced instances receive high-half data with bit 4 set, and mirroring values of $FF and 2. A design that kept the extra bits would show bank bit 8 set or a single-screen A10. For the drop-LSB instance, odd and even low nibbles are compared so that a missing or reversed shift is visible. The bench also interleaves bank and mirroring writes, so that decode leakage between the two register kinds shows up on the outputs.

// File: rtl/chr_bank_file.sv
module chr_bank_file #(
  parameter bit FULL_VARIANT = 1'b1,
  parameter bit DROP_LSB     = 1'b0,
  parameter int SLOTS        = 8,
  parameter int BANK_W       = 9,
  parameter int SLICE_W      = 10,
  parameter int PPU_AW       = 14
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_chr,
  input  logic [1:0]                 wr_grp,
  input  logic [1:0]                 wr_idx,
  input  logic                       wr_mir,
  input  logic [7:0]                 wr_data,
  input  logic [PPU_AW-1:0]          ppu_addr,
  output logic [BANK_W+SLICE_W-1:0]  chr_addr,
  output logic                       ciram_a10
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int LO_W   = 4;
  localparam int HI_W   = BANK_W - LO_W;
  localparam int NT_V   = SLICE_W;
  localparam int NT_H   = SLICE_W + 1;

  logic [BANK_W-1:0] bank_q [SLOTS];
  logic [1:0]        mode_q;
  logic [SLOT_W-1:0] wr_slot, rd_slot;
  logic [HI_W-1:0]   hi_in;
  logic [BANK_W-1:0] bank_sel, bank_out;

  assign wr_slot = {wr_grp, wr_idx[1]};
  assign rd_slot = ppu_addr[SLICE_W +: SLOT_W];
  assign hi_in   = FULL_VARIANT ? wr_data[HI_W-1:0] : {1'b0, wr_data[HI_W-2:0]};

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bank_q[s] <= '0;
      else if (wr_chr && wr_slot == SLOT_W'(s)) begin
        if (wr_idx[0]) bank_q[s][BANK_W-1:LO_W] <= hi_in;
        else           bank_q[s][LO_W-1:0]      <= wr_data[LO_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mode_q <= 2'd0;
    else if (wr_mir)
      mode_q <= FULL_VARIANT ? wr_data[1:0] : {1'b0, wr_data[0]};
  end

  assign bank_sel = bank_q[rd_slot];

  if (DROP_LSB) begin : g_shift
    assign bank_out = {1'b0, bank_sel[BANK_W-1:1]};
  end else begin : g_plain
    assign bank_out = bank_sel;
  end

  assign chr_addr = {bank_out, ppu_addr[SLICE_W-1:0]};

  always_comb begin
    case (mode_q)
      2'd0:    ciram_a10 = ppu_addr[NT_V];
      2'd1:    ciram_a10 = ppu_addr[NT_H];
      2'd2:    ciram_a10 = 1'b0;
      default: ciram_a10 = 1'b1;
    endcase
  end
endmodule

// File: rtl/chr_bank_file_chk.sv
module chr_bank_file_chk #(
  parameter bit FULL    = 1'b1,
  parameter bit SHIFT   = 1'b0,
  parameter int BANK_W  = 9,
  parameter int SLICE_W = 10,
  parameter int PPU_AW  = 14
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_chr,
  input logic [1:0]                wr_grp,
  input logic [1:0]                wr_idx,
  input logic                      wr_mir,
  input logic [7:0]                wr_data,
  input logic [PPU_AW-1:0]         ppu_addr,
  input logic [BANK_W+SLICE_W-1:0] chr_addr,
  input logic                      ciram_a10
);
  localparam int TOP = BANK_W + SLICE_W - 1;

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_chr |=> (!$stable(ppu_addr) || $stable(chr_addr))); // R10

  AST_VERT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mir && wr_data[1:0] == 2'd0) |=> (wr_mir || $past(wr_mir) == 1'b0 || ciram_a10 == ppu_addr[SLICE_W])); // R7

  if (!SHIFT) begin : g_noshift
    AST_LOW_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_chr && !wr_idx[0]) |=> (ppu_addr[SLICE_W+2:SLICE_W] != $past({wr_grp, wr_idx[1]}) ||
                                  chr_addr[SLICE_W+3:SLICE_W] == $past(wr_data[3:0]))); // R2
  end else begin : g_shift
    AST_SHIFT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_chr && !wr_idx[0]) |=> (ppu_addr[SLICE_W+2:SLICE_W] != $past({wr_grp, wr_idx[1]}) ||
                                  (chr_addr[SLICE_W+2:SLICE_W] == $past(wr_data[3:1]) && !chr_addr[TOP]))); // R6
  end

  if (FULL && !SHIFT) begin : g_full
    AST_HIGH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_chr && wr_idx[0]) |=> (ppu_addr[SLICE_W+2:SLICE_W] != $past({wr_grp, wr_idx[1]}) ||
                                 chr_addr[TOP:SLICE_W+4] == $past(wr_data[4:0]))); // R3
    AST_SINGLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mir && wr_data[1:0] == 2'd2) |=> !ciram_a10); // R7
  end

  if (!FULL) begin : g_red
    AST_HORZ_REDUCED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mir && wr_data[0]) |=> (ciram_a10 == ppu_addr[SLICE_W+1])); // R8
    if (!SHIFT) begin : g_rhi
      AST_HIGH_REDUCED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_chr && wr_idx[0]) |=> (ppu_addr[SLICE_W+2:SLICE_W] != $past({wr_grp, wr_idx[1]}) ||
                                   (chr_addr[TOP] == 1'b0 && chr_addr[TOP-1:SLICE_W+4] == $past(wr_data[3:0])))); // R5
    end
  end
endmodule

bind chr_bank_file chr_bank_file_chk #(
  .FULL(FULL_VARIANT), .SHIFT(DROP_LSB), .BANK_W(BANK_W), .SLICE_W(SLICE_W), .PPU_AW(PPU_AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_chr(wr_chr), .wr_grp(wr_grp), .wr_idx(wr_idx),
  .wr_mir(wr_mir), .wr_data(wr_data), .ppu_addr(ppu_addr), .chr_addr(chr_addr),
  .ciram_a10(ciram_a10)
);

// File: tb/chr_bank_file_tb.sv
module chr_bank_file_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_chr = 1'b0, wr_mir = 1'b0;
  logic [1:0]  wr_grp = '0, wr_idx = '0;
  logic [7:0]  wr_data = '0;
  logic [13:0] ppu_addr = '0;
  logic [18:0] a_full, a_red, a_shf;
  logic        n_full, n_red, n_shf;

  int checks = 0, fails = 0;
  logic [8:0] m_full [8];
  logic [8:0] m_red  [8];
  logic [1:0] mo_full, mo_red;

  always #10 clk = ~clk;

  chr_bank_file #(.FULL_VARIANT(1'b1), .DROP_LSB(1'b0)) u_dut (
    .clk, .rst_n, .wr_chr, .wr_grp, .wr_idx, .wr_mir, .wr_data, .ppu_addr,
    .chr_addr(a_full), .ciram_a10(n_full));
  chr_bank_file #(.FULL_VARIANT(1'b0), .DROP_LSB(1'b0)) u_red (
    .clk, .rst_n, .wr_chr, .wr_grp, .wr_idx, .wr_mir, .wr_data, .ppu_addr,
    .chr_addr(a_red), .ciram_a10(n_red));
  chr_bank_file #(.FULL_VARIANT(1'b0), .DROP_LSB(1'b1)) u_shf (
    .clk, .rst_n, .wr_chr, .wr_grp, .wr_idx, .wr_mir, .wr_data, .ppu_addr,
    .chr_addr(a_shf), .ciram_a10(n_shf));

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic a10_of(logic [1:0] m, logic [13:0] a);
    case (m)
      2'd0: return a[10];
      2'd1: return a[11];
      2'd2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic bank_wr(logic [1:0] g, logic [1:0] i, logic [7:0] d);
    int s = g * 2 + i[1];
    @(negedge clk);
    wr_chr = 1'b1; wr_grp = g; wr_idx = i; wr_data = d;
    @(negedge clk);
    wr_chr = 1'b0;
    if (i[0]) begin
      m_full[s][8:4] = d[4:0];
      m_red[s][8:4]  = {1'b0, d[3:0]};
    end else begin
      m_full[s][3:0] = d[3:0];
      m_red[s][3:0]  = d[3:0];
    end
  endtask

  task automatic mir_wr(logic [7:0] d);
    @(negedge clk);
    wr_mir = 1'b1; wr_data = d;
    @(negedge clk);
    wr_mir = 1'b0;
    mo_full = d[1:0];
    mo_red  = {1'b0, d[0]};
  endtask

  task automatic look(string tag, int s, logic [9:0] off);
    ppu_addr = {1'b0, 3'(s), off};
    #2;
    check({tag, " full"},  a_full, {m_full[s], off});
    check({tag, " red"},   a_red,  {m_red[s], off});
    check({tag, " shift"}, a_shf,  {1'b0, m_red[s][8:1], off});
  endtask

  task automatic look_nt(string tag, logic [13:0] a);
    ppu_addr = a;
    #2;
    check({tag, " full"},  n_full, a10_of(mo_full, a));
    check({tag, " red"},   n_red,  a10_of(mo_red, a));
    check({tag, " shift"}, n_shf,  a10_of(mo_red, a));
  endtask

  task automatic t_reset;
    for (int s = 0; s < 8; s++) begin m_full[s] = '0; m_red[s] = '0; end
    mo_full = 2'd0; mo_red = 2'd0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int s = 0; s < 8; s++) look("R9 bank reset", s, 10'h155);
    look_nt("R9 mode reset", 14'h0400);
    look_nt("R9 mode reset", 14'h0800);
    rst_n = 1'b1;
  endtask

  task automatic t_halves;
    bank_wr(2'd0, 2'd1, 8'h1b);
    look("R3 high first", 0, 10'h3ff);
    bank_wr(2'd0, 2'd0, 8'hf6);
    look("R2 low keeps high", 0, 10'h001);
    bank_wr(2'd0, 2'd1, 8'h04);
    look("R3 high keeps low", 0, 10'h200);
    bank_wr(2'd0, 2'd0, 8'h09);
    look("R2 low again", 0, 10'h0aa);
  endtask

  task automatic t_slots;
    for (int s = 0; s < 8; s++) begin
      bank_wr(2'(s / 2), {1'(s % 2), 1'b0}, 8'(s + 3));
      bank_wr(2'(s / 2), {1'(s % 2), 1'b1}, 8'(8'h10 | (s * 3)));
    end
    for (int s = 0; s < 8; s++) look("R1 slot map", s, 10'(s * 37));
  endtask

  task automatic t_comb;
    ppu_addr = 14'h0c12; #2;
    check("R4 comb A", a_full, {m_full[3], 10'h012});
    ppu_addr = 14'h1ff0; #2;
    check("R4 comb B", a_full, {m_full[7], 10'h3f0});
  endtask

  task automatic t_reduced;
    bank_wr(2'd2, 2'd3, 8'hff);
    look("R5 bit4 ignored", 5, 10'h111);
    bank_wr(2'd2, 2'd2, 8'h0f);
    look("R6 odd low", 5, 10'h111);
    bank_wr(2'd2, 2'd2, 8'h0e);
    look("R6 even low", 5, 10'h111);
  endtask

  task automatic t_hold;
    repeat (4) @(negedge clk);
    for (int s = 0; s < 8; s++) look("R10 hold", s, 10'h2c3);
  endtask

  task automatic t_mirror;
    logic [7:0] vals [4] = '{8'h01, 8'h02, 8'h03, 8'hff};
    foreach (vals[k]) begin
      mir_wr(vals[k]);
      look_nt(k == 3 ? "R8 mode FF" : "R7 mode", 14'h0000);
      look_nt(k == 1 ? "R8 mode 2" : "R7 mode", 14'h0400);
      look_nt("R7 mode", 14'h0800);
      look_nt("R7 mode", 14'h0c00);
    end
    mir_wr(8'h00);
    look_nt("R7 vertical", 14'h2400);
    look_nt("R7 vertical", 14'h2800);
  endtask

  task automatic t_isolation;
    mir_wr(8'h03);
    for (int s = 0; s < 8; s++) look("R11 banks after mirror", s, 10'h0f0);
    bank_wr(2'd3, 2'd0, 8'h03);
    bank_wr(2'd1, 2'd1, 8'h1e);
    look_nt("R11 mode after bank", 14'h0000);
    look_nt("R11 mode after bank", 14'h0c00);
    look("R11 bank written", 6, 10'h000);
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_halves();
    t_slots();
    t_comb();
    t_reduced();
    t_hold();
    t_mirror();
    t_isolation();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule